// File: doc/BRIEF.md
# Watchdog Timer with Pre-Warning Pulse

This block watches a single activity line driven by software or a bus signal. Every level change on that line, rising or falling, restarts a timeout period. When a whole period passes with no change, the block first drives a low warning pulse of fixed width. A configurable number of cycles later it drives a level fault output low. The fault output stays low until the activity line next changes. While the line stays idle the period keeps restarting on its own, so a warning pulse appears once per period.

The period length is picked at run time from two parameterised values by a select input. A shutdown flag latches when a warning pulse begins while the fault output is still low from the previous period. Such a pulse marks two periods in a row with no activity. Only a dedicated clear input or the power-on reset removes that flag. The system reset holds the watchdog idle: it clears the period counter and forces both the warning and the fault outputs high. All timing is counted in clock cycles.

Top module: `wdp_watchdog`

## Requirements
- R1: While `sys_rst_n` or `por_n` is low, `warn_n` and `fault_n` are high and the period count is zero. After `sys_rst_n` is released at a clock edge with no input change, `warn_n` falls at the L-th rising edge after release (L is the selected period).
- R2: `wdi` passes through SYNC_STAGES flops. A change in either direction restarts the period. With no further change, `warn_n` falls at the (L + SYNC_STAGES + 1)-th rising edge after the change.
- R3: Each warning pulse holds `warn_n` low for exactly WARN_CYC cycles.
- R4: While `wdi` stays idle the period restarts on every expiry, so `warn_n` falls once every L cycles.
- R5: `fault_n` falls LAG_CYC (at least 1) rising edges after `warn_n` falls, while `warn_n` is still low. It never falls before the warning edge.
- R6: `fault_n` returns high at the edge where an input change is recognised (SYNC_STAGES + 1 edges after the change). A change recognised before the lag has run out cancels the pending fall.
- R7: When a change is recognised in the same cycle the period would expire, the restart wins and no warning pulse is produced.
- R8: `shutdown` rises at the edge where `warn_n` falls if `fault_n` is already low at that point. A change recognised in between keeps it low.
- R9: `shutdown` is cleared at the next edge by `shut_clr`, and at once by `por_n` low. The system reset leaves it unchanged. If a clear and a set fall on the same edge, the clear wins.
- R10: `tmo_sel` = 0 selects DEF_TIMEOUT_CYC and `tmo_sel` = 1 selects ALT_TIMEOUT_CYC as L. The select is applied every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| sys_rst_n | input | 1 | System reset, synchronous, active low; holds the watchdog idle |
| wdi | input | 1 | Activity line watched for level changes |
| tmo_sel | input | 1 | Period select: 0 default, 1 alternative |
| shut_clr | input | 1 | Synchronous clear of the shutdown flag |
| warn_n | output | 1 | Warning pulse, active low |
| fault_n | output | 1 | Fault level, active low |
| shutdown | output | 1 | Two-consecutive-fault flag |

## Verification
Two races are provoked on purpose. In the first, the bench times an input change so that it is recognised in exactly the cycle the counter reaches its limit; no warning pulse may follow. In the second, the change lands on the edge where the lagged fault would fall; the warning pulse must still appear but the fault must not. A third race puts the shutdown clear on the same edge as the set, and the flag must stay low until the following period sets it. The scoreboard judges each race by the absence of the event that would otherwise be queued.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

   typedef enum logic {
      TMO_DEFAULT = 1'b0,
      TMO_ALT     = 1'b1
   } tmo_sel_e;

   function automatic int unsigned wdp_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wdp_sync_edge.sv
module wdp_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic din,
   output logic act
);
   logic [STAGES-1:0] chain;
   logic              prev;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) chain[0] <= 1'b0;
         else        chain[0] <= din;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], din};
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign act = chain[STAGES-1] ^ prev;

   // R2: a recognised change means the settled level has moved by the next edge
   p_act_tracks_r2: assert property (@(posedge clk) disable iff (!por_n)
      act |=> (prev == $past(chain[STAGES-1])));

endmodule

// File: rtl/wdp_period_timer.sv
module wdp_period_timer
   import wdp_pkg::*;
#(
   parameter int unsigned DEF_TIMEOUT_CYC = 160_000_000,
   parameter int unsigned ALT_TIMEOUT_CYC = 40_000_000
) (
   input  logic clk,
   input  logic por_n,
   input  logic run,
   input  logic act,
   input  logic sel,
   output logic expire
);
   localparam int unsigned MAX_CYC = wdp_max(DEF_TIMEOUT_CYC, ALT_TIMEOUT_CYC);
   localparam int unsigned CW      = $clog2(MAX_CYC + 1);
   localparam logic [CW-1:0] DEF_M1 = CW'(DEF_TIMEOUT_CYC - 1);
   localparam logic [CW-1:0] ALT_M1 = CW'(ALT_TIMEOUT_CYC - 1);
   localparam logic [CW-1:0] MAX_M1 = CW'(MAX_CYC - 1);

   tmo_sel_e      mode;
   logic [CW-1:0] lim_m1;
   logic [CW-1:0] cnt;

   assign mode   = tmo_sel_e'(sel);
   assign lim_m1 = (mode == TMO_ALT) ? ALT_M1 : DEF_M1;
   assign expire = run && !act && (cnt >= lim_m1);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)             cnt <= '0;
      else if (!run)          cnt <= '0;
      else if (act || expire) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

   // R2: a recognised change restarts the period
   p_restart_r2: assert property (@(posedge clk) disable iff (!por_n)
      (run && act) |=> (cnt == '0));
   // R10: the count never passes the longer of the two limits
   p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!por_n)
      cnt <= MAX_M1);
   // R1: held at zero while the system reset is active
   p_idle_zero_r1: assert property (@(posedge clk) disable iff (!por_n)
      !run |=> (cnt == '0));

endmodule

// File: rtl/wdp_pulse_gen.sv
module wdp_pulse_gen #(
   parameter int unsigned WARN_CYC = 170_000,
   parameter int unsigned LAG_CYC  = 7
) (
   input  logic clk,
   input  logic por_n,
   input  logic run,
   input  logic expire,
   input  logic act,
   output logic warn_n,
   output logic fault_n
);
   localparam int unsigned WCW = $clog2(WARN_CYC + 1);
   localparam int unsigned LCW = $clog2(LAG_CYC + 1);

   logic [WCW-1:0] wcnt;
   logic [LCW-1:0] lcnt;
   logic           lag_busy;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         warn_n <= 1'b1;
         wcnt   <= '0;
      end else if (!run) begin
         warn_n <= 1'b1;
         wcnt   <= '0;
      end else if (expire) begin
         warn_n <= 1'b0;
         wcnt   <= WCW'(WARN_CYC - 1);
      end else if (!warn_n) begin
         if (wcnt == '0) warn_n <= 1'b1;
         else            wcnt   <= wcnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         fault_n  <= 1'b1;
         lag_busy <= 1'b0;
         lcnt     <= '0;
      end else if (!run) begin
         fault_n  <= 1'b1;
         lag_busy <= 1'b0;
         lcnt     <= '0;
      end else if (act) begin
         fault_n  <= 1'b1;
         lag_busy <= 1'b0;
      end else if (expire) begin
         lag_busy <= 1'b1;
         lcnt     <= LCW'(LAG_CYC);
      end else if (lag_busy) begin
         if (lcnt == LCW'(1)) begin
            fault_n  <= 1'b0;
            lag_busy <= 1'b0;
         end else begin
            lcnt <= lcnt - 1'b1;
         end
      end
   end

   // R5: the fault edge never leads the warning edge
   p_fault_after_warn_r5: assert property (@(posedge clk) disable iff (!por_n)
      $fell(fault_n) |-> !warn_n);
   // R6: a recognised change lifts the fault
   p_act_clears_r6: assert property (@(posedge clk) disable iff (!por_n)
      (run && act) |=> fault_n);
   // R1: both outputs high while the system reset is active
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!por_n)
      !run |=> (warn_n && fault_n));
   // R3: a pulse only starts on an expiry
   p_warn_start_r3: assert property (@(posedge clk) disable iff (!por_n)
      $fell(warn_n) |-> $past(expire));

endmodule

// File: rtl/wdp_shut_latch.sv
module wdp_shut_latch (
   input  logic clk,
   input  logic por_n,
   input  logic set_ev,
   input  logic clr,
   output logic shutdown
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      shutdown <= 1'b0;
      else if (clr)    shutdown <= 1'b0;
      else if (set_ev) shutdown <= 1'b1;
   end

   // R9: a clear always wins at the next edge
   p_clr_wins_r9: assert property (@(posedge clk) disable iff (!por_n)
      clr |=> !shutdown);
   // R9: without a set or a clear the flag holds
   p_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
      (!clr && !set_ev) |=> $stable(shutdown));

endmodule

// File: rtl/wdp_watchdog.sv
module wdp_watchdog #(
   parameter int unsigned DEF_TIMEOUT_CYC = 160_000_000,
   parameter int unsigned ALT_TIMEOUT_CYC = 40_000_000,
   parameter int unsigned WARN_CYC        = 170_000,
   parameter int unsigned LAG_CYC         = 7,
   parameter int unsigned SYNC_STAGES     = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic sys_rst_n,
   input  logic wdi,
   input  logic tmo_sel,
   input  logic shut_clr,
   output logic warn_n,
   output logic fault_n,
   output logic shutdown
);
   if (SYNC_STAGES < 1) begin : g_err_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (LAG_CYC < 1) begin : g_err_lag
      $error("LAG_CYC must be at least 1");
   end
   if (LAG_CYC >= WARN_CYC) begin : g_err_lag_warn
      $error("LAG_CYC must be shorter than WARN_CYC");
   end
   if (WARN_CYC >= DEF_TIMEOUT_CYC || WARN_CYC >= ALT_TIMEOUT_CYC) begin : g_err_warn
      $error("WARN_CYC must be shorter than both periods");
   end

   logic act;
   logic expire;
   logic run;

   assign run = sys_rst_n;

   wdp_sync_edge #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .din   (wdi),
      .act   (act)
   );

   wdp_period_timer #(
      .DEF_TIMEOUT_CYC (DEF_TIMEOUT_CYC),
      .ALT_TIMEOUT_CYC (ALT_TIMEOUT_CYC)
   ) u_timer (
      .clk    (clk),
      .por_n  (por_n),
      .run    (run),
      .act    (act),
      .sel    (tmo_sel),
      .expire (expire)
   );

   wdp_pulse_gen #(
      .WARN_CYC (WARN_CYC),
      .LAG_CYC  (LAG_CYC)
   ) u_pulse (
      .clk     (clk),
      .por_n   (por_n),
      .run     (run),
      .expire  (expire),
      .act     (act),
      .warn_n  (warn_n),
      .fault_n (fault_n)
   );

   wdp_shut_latch u_latch (
      .clk      (clk),
      .por_n    (por_n),
      .set_ev   (expire && !fault_n),
      .clr      (shut_clr),
      .shutdown (shutdown)
   );

   // R8: the flag only rises together with a warning edge
   p_shut_on_warn_r8: assert property (@(posedge clk) disable iff (!por_n)
      $rose(shutdown) |-> $fell(warn_n));
   // R8: the flag only rises when the fault was already low
   p_shut_needs_fault_r8: assert property (@(posedge clk) disable iff (!por_n)
      $rose(shutdown) |-> !$past(fault_n));

endmodule

// File: tb/wdp_watchdog_bench.sv
module wdp_watchdog_bench;
   localparam int L_DEF = 40;
   localparam int L_ALT = 24;
   localparam int WCYC  = 6;
   localparam int LAG   = 2;
   localparam int SYN   = 2;
   localparam int DLY   = SYN + 1;

   localparam int K_WF = 0, K_WR = 1, K_FF = 2, K_FR = 3, K_SR = 4, K_SF = 5;

   logic clk = 1'b0;
   logic por_n = 1'b0, sys_rst_n = 1'b0, wdi = 1'b0, tmo_sel = 1'b0, shut_clr = 1'b0;
   logic warn_n, fault_n, shutdown;

   always #5 clk = ~clk;

   wdp_watchdog #(
      .DEF_TIMEOUT_CYC (L_DEF),
      .ALT_TIMEOUT_CYC (L_ALT),
      .WARN_CYC        (WCYC),
      .LAG_CYC         (LAG),
      .SYNC_STAGES     (SYN)
   ) u_wdp_watchdog (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .wdi       (wdi),
      .tmo_sel   (tmo_sel),
      .shut_clr  (shut_clr),
      .warn_n    (warn_n),
      .fault_n   (fault_n),
      .shutdown  (shutdown)
   );

   typedef struct {
      int    kind;
      int    at;
      string tag;
   } ev_t;

   ev_t   exp_q[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    mon_en = 0;
   bit    done = 0;
   logic  pw, pf, ps;

   always @(posedge clk) cyc++;

   function automatic string kname(input int k);
      case (k)
         K_WF: return "warn fall";
         K_WR: return "warn rise";
         K_FF: return "fault fall";
         K_FR: return "fault rise";
         K_SR: return "shutdown rise";
         default: return "shutdown fall";
      endcase
   endfunction

   function automatic string ktag(input int k);
      if (k <= K_WR) return "R3";
      if (k <= K_FR) return "R5";
      return "R8";
   endfunction

   task automatic expect_ev(input int kind, input int at, input string tag);
      ev_t e;
      e.kind = kind; e.at = at; e.tag = tag;
      exp_q.push_back(e);
   endtask

   function automatic void seen(input int kind);
      int hit = -1;
      foreach (exp_q[i])
         if (hit < 0 && exp_q[i].kind == kind && exp_q[i].at == cyc) hit = i;
      checks++;
      if (hit >= 0) begin
         exp_q.delete(hit);
      end else begin
         errors++;
         $display("FAIL %s: actual %s at cycle %0d, expected no such event", ktag(kind), kname(kind), cyc);
      end
   endfunction

   // monitor: compares every output change against the queue
   always @(negedge clk) begin
      if (mon_en) begin
         if (warn_n !== pw)   seen(warn_n ? K_WR : K_WF);
         if (fault_n !== pf)  seen(fault_n ? K_FR : K_FF);
         if (shutdown !== ps) seen(shutdown ? K_SR : K_SF);
      end
      pw = warn_n; pf = fault_n; ps = shutdown;
   end

   task automatic chk(input bit ok, input string tag, input string what, input int act_v, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual %0d expected %0d", tag, what, act_v, exp_v);
      end
   endtask

   task automatic until_cyc(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic toggle();
      wdi = ~wdi;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      finish_run();
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(warn_n === 1'b1, "R1", "warn_n in reset", warn_n, 1);
      chk(fault_n === 1'b1, "R1", "fault_n in reset", fault_n, 1);
      chk(shutdown === 1'b0, "R9", "shutdown after power-on reset", shutdown, 0);
      por_n = 1'b1;
      sys_rst_n = 1'b1;
      mon_en = 1;

      // R2 regular activity: no events at all
      for (int i = 0; i < 5; i++) begin
         toggle();
         repeat (20) @(negedge clk);
      end

      // R2 R3 R5 R6 single timeout, then recovery
      c = cyc; toggle();
      expect_ev(K_WF, c + L_DEF + DLY, "R2");
      expect_ev(K_FF, c + L_DEF + DLY + LAG, "R5");
      expect_ev(K_WR, c + L_DEF + DLY + WCYC, "R3");
      until_cyc(c + 60); toggle();
      expect_ev(K_FR, c + 60 + DLY, "R6");
      until_cyc(c + 75);

      // R4 R8 R9 repeated timeouts, clear racing the set
      c = cyc; toggle();
      expect_ev(K_WF, c + 43, "R2");
      expect_ev(K_FF, c + 45, "R5");
      expect_ev(K_WR, c + 49, "R3");
      expect_ev(K_WF, c + 83, "R4");
      expect_ev(K_WR, c + 89, "R4");
      expect_ev(K_WF, c + 123, "R4");
      expect_ev(K_WR, c + 129, "R4");
      expect_ev(K_SR, c + 123, "R8");
      until_cyc(c + 82); shut_clr = 1'b1;   // clear on the set edge c+83: R9 clear wins
      until_cyc(c + 83); shut_clr = 1'b0;
      until_cyc(c + 130); toggle();
      expect_ev(K_FR, c + 133, "R6");
      until_cyc(c + 140);
      chk(shutdown === 1'b1, "R8", "shutdown after second idle period", shutdown, 1);
      sys_rst_n = 1'b0;
      until_cyc(c + 143);
      chk(warn_n === 1'b1 && fault_n === 1'b1, "R1", "outputs high in system reset", {warn_n, fault_n}, 3);
      until_cyc(c + 145); sys_rst_n = 1'b1; toggle();
      until_cyc(c + 150);
      chk(shutdown === 1'b1, "R9", "shutdown kept over system reset", shutdown, 1);
      until_cyc(c + 152); shut_clr = 1'b1;
      until_cyc(c + 153); shut_clr = 1'b0;
      expect_ev(K_SF, c + 153, "R9");
      until_cyc(c + 160);

      // R10 alternative period
      c = cyc; toggle();
      until_cyc(c + 5); tmo_sel = 1'b1; toggle();
      expect_ev(K_WF, c + 5 + DLY + L_ALT, "R10");
      expect_ev(K_FF, c + 5 + DLY + L_ALT + LAG, "R10");
      expect_ev(K_WR, c + 5 + DLY + L_ALT + WCYC, "R10");
      expect_ev(K_WF, c + 5 + DLY + 2 * L_ALT, "R4");
      expect_ev(K_WR, c + 5 + DLY + 2 * L_ALT + WCYC, "R4");
      expect_ev(K_SR, c + 5 + DLY + 2 * L_ALT, "R8");
      until_cyc(c + 60); toggle();
      expect_ev(K_FR, c + 63, "R6");
      until_cyc(c + 65); tmo_sel = 1'b0; toggle();
      until_cyc(c + 66); shut_clr = 1'b1;
      until_cyc(c + 67); shut_clr = 1'b0;
      expect_ev(K_SF, c + 67, "R9");
      until_cyc(c + 75);

      // R7 restart racing expiry, R6 restart racing the lagged fault
      c = cyc; toggle();
      until_cyc(c + 40); toggle();   // recognised at c+43, the expiry edge
      until_cyc(c + 80); toggle();   // recognised at c+83, the expiry edge again
      until_cyc(c + 122); toggle();  // recognised at c+125, the lagged fault edge
      expect_ev(K_WF, c + 123, "R7");
      expect_ev(K_WR, c + 129, "R3");
      until_cyc(c + 140); toggle();
      until_cyc(c + 150);
      chk(fault_n === 1'b1, "R6", "fault cancelled by change in lag", fault_n, 1);

      // R1 system reset mid fault, then timing from release
      c = cyc; toggle();
      expect_ev(K_WF, c + 43, "R2");
      expect_ev(K_FF, c + 45, "R5");
      until_cyc(c + 46); sys_rst_n = 1'b0;
      expect_ev(K_WR, c + 47, "R1");
      expect_ev(K_FR, c + 47, "R1");
      until_cyc(c + 55); sys_rst_n = 1'b1;
      expect_ev(K_WF, c + 55 + L_DEF, "R1");
      expect_ev(K_FF, c + 55 + L_DEF + LAG, "R5");
      expect_ev(K_WR, c + 55 + L_DEF + WCYC, "R3");
      until_cyc(c + 110); toggle();
      expect_ev(K_FR, c + 110 + DLY, "R6");
      until_cyc(c + 125); toggle();
      repeat (10) @(negedge clk);

      // R9 power-on reset
      mon_en = 0;
      por_n = 1'b0;
      #1;
      chk(shutdown === 1'b0, "R9", "shutdown under power-on reset", shutdown, 0);
      chk(warn_n === 1'b1 && fault_n === 1'b1, "R1", "outputs under power-on reset", {warn_n, fault_n}, 3);

      foreach (exp_q[i]) begin
         checks++;
         errors++;
         $display("FAIL %s: actual no %s, expected it at cycle %0d", exp_q[i].tag, kname(exp_q[i].kind), exp_q[i].at);
      end
      finish_run();
   end
endmodule